// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block sits beside the pipeline of a core with three privilege levels (user, supervisor, machine) and performs the state update that happens when a trap is accepted. A trap request carries the trap code, an interrupt flag, a non-maskable flag, the PC of the trapping instruction and a trap value. The block decides which privilege level handles the trap, from the current privilege, whether supervisor mode exists and two delegation masks. In a single clock edge it records cause, exception PC and trap value in the register set of that level. It saves and clears the interrupt-enable state, switches privilege, drops any outstanding load reservation and presents the handler address to fetch.

Non-maskable interrupts take a separate resumable path. They have their own cause and PC registers and their own saved-privilege field. They leave the machine status fields untouched and mask further non-maskable requests until the return logic re-enables them. A small restore port lets the return logic load the privilege and enable bits after a handler returns. The block itself does not decode the return instructions.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the privilege is machine (3), MIE, SIE and MPRV are 0, the non-maskable enable is 1, the reservation is clear, and `redirectValid` is 1 with `redirectPc` equal to the reset vector parameter.
- R2: A non-maskable trap is always handled in machine mode. Any other trap goes to supervisor mode only when all three of these hold: the current privilege is not machine, `sModeImpl` is 1, and bit `trapCode` of `midelegIn` (interrupt) or `medelegIn` (exception) is 1. Every other trap goes to machine mode.
- R3: On supervisor entry, `spp` takes bit 0 of the previous privilege, `spie` takes the old `sie`, and `sie` becomes 0. `scause`, `sepc` and `stval` are written, the privilege becomes 1, and the machine fields are unchanged.
- R4: On machine entry, `mpp` takes the previous privilege, `mpie` takes the old `mie`, and `mie` becomes 0. `mcause`, `mepc` and `mtval` are written, the privilege becomes 3, and the supervisor fields are unchanged.
- R5: On an accepted non-maskable trap, `nmiCause` and `nmiEpc` are written and `nmiPrevPriv` takes the previous privilege. The privilege becomes 3, `nmiEnable` becomes 0, and `mie`, `mpie`, `mpp`, `mcause` and `mepc` are unchanged.
- R6: A non-maskable trap presented while `nmiEnable` is 0 has no effect: no redirect, and no trap register, status field or privilege changes.
- R7: The cause value holds `trapCode` in its low CODE_W bits and zeros above them. Bit XLEN-1 is 1 exactly when `trapIsIrq` is 1.
- R8: The saved PC is `trapPc`, or `tjPc` when `tjSecond` is 1. In that case `tjCancel` is 1 in the cycle after the entry and 0 otherwise.
- R9: Every accepted trap leaves `resvValid` at 0. Without a trap, `reserveSet` sets it to 1.
- R10: One cycle after an accepted trap, `redirectValid` is 1 and `redirectPc` is the handler address. A non-maskable trap uses the NMI vector parameter. Otherwise the selected vector register is used with its low two bits cleared. When those low two bits are 1 and the trap is an interrupt, 4 times the code is added. Without a trap, `redirectValid` is 0 and `redirectPc` holds its value.
- R11: With `resumeEn` and no accepted trap, the privilege, `mie`, `sie`, `mprv` and `nmiEnable` are loaded from the restore inputs. A restore privilege of 2 is refused: the state is left unchanged and `privError` is 1 in the following cycle.
- R12: The privilege register never holds 2, and no trap targets user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | Trap request this cycle |
| trapCode | input | CODE_W | Exception or interrupt code |
| trapIsIrq | input | 1 | Request is an interrupt |
| trapIsNmi | input | 1 | Request is a non-maskable interrupt |
| trapPc | input | XLEN | PC of trapping instruction |
| trapTval | input | XLEN | Trap value |
| tjSecond | input | 1 | Table-jump second fetch in progress |
| tjPc | input | XLEN | Saved table-jump PC |
| midelegIn | input | 2**CODE_W | Interrupt delegation mask |
| medelegIn | input | 2**CODE_W | Exception delegation mask |
| sModeImpl | input | 1 | Supervisor mode is implemented |
| mtvecIn | input | XLEN | Machine trap vector (low 2 bits = mode) |
| stvecIn | input | XLEN | Supervisor trap vector (low 2 bits = mode) |
| resumeEn | input | 1 | Restore request from return logic |
| resumePriv | input | 2 | Privilege to restore |
| resumeMie | input | 1 | MIE to restore |
| resumeSie | input | 1 | SIE to restore |
| resumeMprv | input | 1 | MPRV to restore |
| resumeNmie | input | 1 | Non-maskable enable to restore |
| reserveSet | input | 1 | Load-reserved executed |
| curPriv | output | 2 | Current privilege |
| mie | output | 1 | Machine interrupt enable |
| mpie | output | 1 | Saved machine interrupt enable |
| mpp | output | 2 | Machine previous privilege |
| sie | output | 1 | Supervisor interrupt enable |
| spie | output | 1 | Saved supervisor interrupt enable |
| spp | output | 1 | Supervisor previous privilege |
| mprv | output | 1 | Modify-privilege bit |
| mcause | output | XLEN | Machine cause |
| mepc | output | XLEN | Machine exception PC |
| mtval | output | XLEN | Machine trap value |
| scause | output | XLEN | Supervisor cause |
| sepc | output | XLEN | Supervisor exception PC |
| stval | output | XLEN | Supervisor trap value |
| nmiCause | output | XLEN | Non-maskable cause |
| nmiEpc | output | XLEN | Non-maskable exception PC |
| nmiPrevPriv | output | 2 | Privilege before the non-maskable trap |
| nmiEnable | output | 1 | Non-maskable interrupts enabled |
| resvValid | output | 1 | Load reservation outstanding |
| tjCancel | output | 1 | Clear table-jump second-fetch state |
| redirectValid | output | 1 | Fetch redirect strobe |
| redirectPc | output | XLEN | Fetch redirect target |
| privError | output | 1 | Illegal restore privilege refused |

## Verification
The bench targets the delegation corners: a delegated code raised from machine mode, delegation with supervisor mode absent, and the interrupt and exception masks with different bits set. A design that consults the wrong mask or ignores the current privilege would write the wrong level's cause and PC. It drives back-to-back non-maskable requests to show that the second is dropped; a design missing the mask would overwrite the saved PC. It also sends vectored interrupts at the top code next to vectored exceptions, so a design that applies the vector offset to exceptions lands on the wrong handler. Finally it restores privilege 2, which a design without the guard would accept and leave as an illegal level.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeM;
    logic takeS;
    logic takeNmi;
    logic doResume;
    logic badResume;
  } trapStrobes_t;

endpackage

// File: rtl/trap_target_ctrl.sv
module trap_target_ctrl
  import trap_entry_pkg::*;
#(
  parameter int CODE_W = 4,
  localparam int DELEG_W = 1 << CODE_W
) (
  input  logic               trapValid,
  input  logic [CODE_W-1:0]  trapCode,
  input  logic               trapIsIrq,
  input  logic               trapIsNmi,
  input  logic [DELEG_W-1:0] midelegIn,
  input  logic [DELEG_W-1:0] medelegIn,
  input  logic               sModeImpl,
  input  logic [1:0]         curPriv,
  input  logic               nmiEnable,
  input  logic               resumeEn,
  input  logic [1:0]         resumePriv,
  output trapStrobes_t       strobes
);

  logic nmiAccept;
  logic normalTrap;
  logic delegBit;
  logic goSuper;
  logic anyTake;
  logic resumeLegal;

  always_comb begin
    nmiAccept   = trapValid && trapIsNmi && nmiEnable;
    normalTrap  = trapValid && !trapIsNmi;
    delegBit    = trapIsIrq ? midelegIn[trapCode] : medelegIn[trapCode];
    goSuper     = normalTrap && (curPriv != PRIV_M) && sModeImpl && delegBit;
    anyTake     = nmiAccept || normalTrap;
    resumeLegal = (resumePriv != PRIV_RSVD);

    strobes.takeNmi   = nmiAccept;
    strobes.takeS     = goSuper;
    strobes.takeM     = normalTrap && !goSuper;
    strobes.doResume  = resumeEn && !anyTake && resumeLegal;
    strobes.badResume = resumeEn && !anyTake && !resumeLegal;
  end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CODE_W = 4,
  parameter logic [XLEN-1:0] NMI_VEC = '0
) (
  input  trapStrobes_t      strobes,
  input  logic [CODE_W-1:0] trapCode,
  input  logic              trapIsIrq,
  input  logic [XLEN-1:0]   mtvecIn,
  input  logic [XLEN-1:0]   stvecIn,
  output logic [XLEN-1:0]   handlerPc
);

  localparam logic [1:0] MODE_VECTORED = 2'd1;

  logic [XLEN-1:0] selVec;
  logic [XLEN-1:0] baseAddr;
  logic [XLEN-1:0] offset;

  always_comb begin
    selVec   = strobes.takeS ? stvecIn : mtvecIn;
    baseAddr = {selVec[XLEN-1:2], 2'b00};
    offset   = '0;
    if (selVec[1:0] == MODE_VECTORED && trapIsIrq)
      offset = XLEN'(trapCode) << 2;
    if (strobes.takeNmi)
      handlerPc = NMI_VEC;
    else
      handlerPc = baseAddr + offset;
  end

endmodule

// File: rtl/trap_state_dpath.sv
module trap_state_dpath
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CODE_W = 4,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobes_t      strobes,
  input  logic [CODE_W-1:0] trapCode,
  input  logic              trapIsIrq,
  input  logic [XLEN-1:0]   trapPc,
  input  logic [XLEN-1:0]   trapTval,
  input  logic              tjSecond,
  input  logic [XLEN-1:0]   tjPc,
  input  logic [XLEN-1:0]   handlerPc,
  input  logic [1:0]        resumePriv,
  input  logic              resumeMie,
  input  logic              resumeSie,
  input  logic              resumeMprv,
  input  logic              resumeNmie,
  input  logic              reserveSet,
  output logic [1:0]        curPriv,
  output logic              mie,
  output logic              mpie,
  output logic [1:0]        mpp,
  output logic              sie,
  output logic              spie,
  output logic              spp,
  output logic              mprv,
  output logic [XLEN-1:0]   mcause,
  output logic [XLEN-1:0]   mepc,
  output logic [XLEN-1:0]   mtval,
  output logic [XLEN-1:0]   scause,
  output logic [XLEN-1:0]   sepc,
  output logic [XLEN-1:0]   stval,
  output logic [XLEN-1:0]   nmiCause,
  output logic [XLEN-1:0]   nmiEpc,
  output logic [1:0]        nmiPrevPriv,
  output logic              nmiEnable,
  output logic              resvValid,
  output logic              tjCancel,
  output logic              redirectValid,
  output logic [XLEN-1:0]   redirectPc,
  output logic              privError
);

  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic [XLEN-1:0] causeVal;
  logic [XLEN-1:0] epcVal;
  logic            anyTake;

  always_comb begin
    causeVal = {trapIsIrq, {PAD_W{1'b0}}, trapCode};
    epcVal   = tjSecond ? tjPc : trapPc;
    anyTake  = strobes.takeM || strobes.takeS || strobes.takeNmi;
  end

  // Privilege and status fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPriv     <= PRIV_M;
      mie         <= 1'b0;
      mpie        <= 1'b0;
      mpp         <= PRIV_U;
      sie         <= 1'b0;
      spie        <= 1'b0;
      spp         <= 1'b0;
      mprv        <= 1'b0;
      nmiPrevPriv <= PRIV_U;
      nmiEnable   <= 1'b1;
    end else if (strobes.takeNmi) begin
      nmiPrevPriv <= curPriv;
      nmiEnable   <= 1'b0;
      curPriv     <= PRIV_M;
    end else if (strobes.takeM) begin
      mpp     <= curPriv;
      mpie    <= mie;
      mie     <= 1'b0;
      curPriv <= PRIV_M;
    end else if (strobes.takeS) begin
      spp     <= curPriv[0];
      spie    <= sie;
      sie     <= 1'b0;
      curPriv <= PRIV_S;
    end else if (strobes.doResume) begin
      curPriv   <= resumePriv;
      mie       <= resumeMie;
      sie       <= resumeSie;
      mprv      <= resumeMprv;
      nmiEnable <= resumeNmie;
    end
  end

  // Trap record registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcause   <= '0;
      mepc     <= '0;
      mtval    <= '0;
      scause   <= '0;
      sepc     <= '0;
      stval    <= '0;
      nmiCause <= '0;
      nmiEpc   <= '0;
    end else begin
      if (strobes.takeM) begin
        mcause <= causeVal;
        mepc   <= epcVal;
        mtval  <= trapTval;
      end
      if (strobes.takeS) begin
        scause <= causeVal;
        sepc   <= epcVal;
        stval  <= trapTval;
      end
      if (strobes.takeNmi) begin
        nmiCause <= causeVal;
        nmiEpc   <= epcVal;
      end
    end
  end

  // Reservation, redirect and side strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValid     <= 1'b0;
      tjCancel      <= 1'b0;
      redirectValid <= 1'b1;
      redirectPc    <= RESET_VEC;
      privError     <= 1'b0;
    end else begin
      if (anyTake)
        resvValid <= 1'b0;
      else if (reserveSet)
        resvValid <= 1'b1;
      tjCancel      <= anyTake && tjSecond;
      redirectValid <= anyTake;
      if (anyTake)
        redirectPc <= handlerPc;
      privError <= strobes.badResume;
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CODE_W = 4,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
  parameter logic [XLEN-1:0] NMI_VEC = 32'h0000_0200,
  localparam int DELEG_W = 1 << CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic [CODE_W-1:0]  trapCode,
  input  logic               trapIsIrq,
  input  logic               trapIsNmi,
  input  logic [XLEN-1:0]    trapPc,
  input  logic [XLEN-1:0]    trapTval,
  input  logic               tjSecond,
  input  logic [XLEN-1:0]    tjPc,
  input  logic [DELEG_W-1:0] midelegIn,
  input  logic [DELEG_W-1:0] medelegIn,
  input  logic               sModeImpl,
  input  logic [XLEN-1:0]    mtvecIn,
  input  logic [XLEN-1:0]    stvecIn,
  input  logic               resumeEn,
  input  logic [1:0]         resumePriv,
  input  logic               resumeMie,
  input  logic               resumeSie,
  input  logic               resumeMprv,
  input  logic               resumeNmie,
  input  logic               reserveSet,
  output logic [1:0]         curPriv,
  output logic               mie,
  output logic               mpie,
  output logic [1:0]         mpp,
  output logic               sie,
  output logic               spie,
  output logic               spp,
  output logic               mprv,
  output logic [XLEN-1:0]    mcause,
  output logic [XLEN-1:0]    mepc,
  output logic [XLEN-1:0]    mtval,
  output logic [XLEN-1:0]    scause,
  output logic [XLEN-1:0]    sepc,
  output logic [XLEN-1:0]    stval,
  output logic [XLEN-1:0]    nmiCause,
  output logic [XLEN-1:0]    nmiEpc,
  output logic [1:0]         nmiPrevPriv,
  output logic               nmiEnable,
  output logic               resvValid,
  output logic               tjCancel,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic               privError
);

  trapStrobes_t    strobes;
  logic [XLEN-1:0] handlerPc;

  trap_target_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .trapValid (trapValid),
    .trapCode  (trapCode),
    .trapIsIrq (trapIsIrq),
    .trapIsNmi (trapIsNmi),
    .midelegIn (midelegIn),
    .medelegIn (medelegIn),
    .sModeImpl (sModeImpl),
    .curPriv   (curPriv),
    .nmiEnable (nmiEnable),
    .resumeEn  (resumeEn),
    .resumePriv(resumePriv),
    .strobes   (strobes)
  );

  trap_vector_gen #(.XLEN(XLEN), .CODE_W(CODE_W), .NMI_VEC(NMI_VEC)) u_vec (
    .strobes  (strobes),
    .trapCode (trapCode),
    .trapIsIrq(trapIsIrq),
    .mtvecIn  (mtvecIn),
    .stvecIn  (stvecIn),
    .handlerPc(handlerPc)
  );

  trap_state_dpath #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RESET_VEC)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .trapCode     (trapCode),
    .trapIsIrq    (trapIsIrq),
    .trapPc       (trapPc),
    .trapTval     (trapTval),
    .tjSecond     (tjSecond),
    .tjPc         (tjPc),
    .handlerPc    (handlerPc),
    .resumePriv   (resumePriv),
    .resumeMie    (resumeMie),
    .resumeSie    (resumeSie),
    .resumeMprv   (resumeMprv),
    .resumeNmie   (resumeNmie),
    .reserveSet   (reserveSet),
    .curPriv      (curPriv),
    .mie          (mie),
    .mpie         (mpie),
    .mpp          (mpp),
    .sie          (sie),
    .spie         (spie),
    .spp          (spp),
    .mprv         (mprv),
    .mcause       (mcause),
    .mepc         (mepc),
    .mtval        (mtval),
    .scause       (scause),
    .sepc         (sepc),
    .stval        (stval),
    .nmiCause     (nmiCause),
    .nmiEpc       (nmiEpc),
    .nmiPrevPriv  (nmiPrevPriv),
    .nmiEnable    (nmiEnable),
    .resvValid    (resvValid),
    .tjCancel     (tjCancel),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc),
    .privError    (privError)
  );

endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapValid,
  input logic            trapIsNmi,
  input logic            trapIsIrq,
  input logic [1:0]      curPriv,
  input logic            nmiEnable,
  input logic [XLEN-1:0] nmiEpc,
  input logic            redirectValid,
  input logic            mie,
  input logic            mpie,
  input logic [1:0]      mpp,
  input logic            resvValid,
  input logic [XLEN-1:0] mcause
);

  assert_priv_legal_R12: assert property (@(posedge clk) disable iff (!rstN)
    curPriv != 2'd2);

  assert_nmi_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && trapIsNmi && nmiEnable |=> !nmiEnable && curPriv == 2'd3);

  assert_nmi_keeps_mstatus_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && trapIsNmi && nmiEnable |=> $stable(mie) && $stable(mpie) && $stable(mpp));

  assert_masked_nmi_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && trapIsNmi && !nmiEnable |=> !redirectValid && $stable(nmiEpc));

  assert_resv_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && (!trapIsNmi || nmiEnable) |=> !resvValid);

  assert_m_stays_R2: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && !trapIsNmi && curPriv == 2'd3 |=> curPriv == 2'd3 && !mie);

  assert_irq_msb_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && !trapIsNmi && trapIsIrq && curPriv == 2'd3 |=> mcause[XLEN-1]);

endmodule

bind trap_entry_unit trap_entry_checker #(.XLEN(XLEN)) u_checker (.*);

// File: tb/tb_trap_entry_unit.sv
`timescale 1ns/1ps
module tb_trap_entry_unit;

  localparam int XLEN = 32;
  localparam int CODE_W = 4;
  localparam int DW = 1 << CODE_W;
  localparam logic [XLEN-1:0] RVEC = 32'h0000_1000;
  localparam logic [XLEN-1:0] NVEC = 32'h0000_0200;

  logic clk = 0;
  logic rstN = 0;
  logic trapValid = 0, trapIsIrq = 0, trapIsNmi = 0, tjSecond = 0;
  logic [CODE_W-1:0] trapCode = 0;
  logic [XLEN-1:0] trapPc = 0, trapTval = 0, tjPc = 0, mtvecIn = 0, stvecIn = 0;
  logic [DW-1:0] midelegIn = 0, medelegIn = 0;
  logic sModeImpl = 1;
  logic resumeEn = 0, resumeMie = 0, resumeSie = 0, resumeMprv = 0, resumeNmie = 0;
  logic [1:0] resumePriv = 0;
  logic reserveSet = 0;

  logic [1:0] curPriv, mpp, nmiPrevPriv;
  logic mie, mpie, sie, spie, spp, mprv, nmiEnable, resvValid, tjCancel, redirectValid, privError;
  logic [XLEN-1:0] mcause, mepc, mtval, scause, sepc, stval, nmiCause, nmiEpc, redirectPc;

  trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RVEC), .NMI_VEC(NVEC)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // Expected state
  logic [1:0] ePriv, eMpp, eNpp;
  logic eMie, eMpie, eSie, eSpie, eSpp, eMprv, eNmie, eResv, eTj, eRv, eErr;
  logic [XLEN-1:0] eMc, eMe, eMt, eSc, eSe, eSt, eNc, eNe, eRpc;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    ePriv = 3; eMpp = 0; eNpp = 0; eMie = 0; eMpie = 0; eSie = 0; eSpie = 0; eSpp = 0;
    eMprv = 0; eNmie = 1; eResv = 0; eTj = 0; eRv = 1; eErr = 0; eRpc = RVEC;
    eMc = 0; eMe = 0; eMt = 0; eSc = 0; eSe = 0; eSt = 0; eNc = 0; eNe = 0;
  endtask

  function automatic logic [XLEN-1:0] handler(input logic [XLEN-1:0] tv, input logic irq,
                                               input logic [CODE_W-1:0] c);
    logic [XLEN-1:0] b;
    b = {tv[XLEN-1:2], 2'b00};
    if (tv[1:0] == 2'd1 && irq) b = b + 4 * c;
    return b;
  endfunction

  task automatic modelStep();
    logic nmiT, normT, toS, anyT, dlg;
    logic [XLEN-1:0] cause, epc;
    nmiT  = trapValid && trapIsNmi && eNmie;
    normT = trapValid && !trapIsNmi;
    dlg   = trapIsIrq ? midelegIn[trapCode] : medelegIn[trapCode];
    toS   = normT && ePriv != 3 && sModeImpl && dlg;
    anyT  = nmiT || normT;
    cause = {trapIsIrq, {(XLEN-1-CODE_W){1'b0}}, trapCode};
    epc   = tjSecond ? tjPc : trapPc;
    eErr  = 0;
    if (nmiT) begin
      eNc = cause; eNe = epc; eNpp = ePriv; eNmie = 0; ePriv = 3; eRpc = NVEC;
    end else if (toS) begin
      eSc = cause; eSe = epc; eSt = trapTval; eSpp = ePriv[0]; eSpie = eSie; eSie = 0;
      ePriv = 1; eRpc = handler(stvecIn, trapIsIrq, trapCode);
    end else if (normT) begin
      eMc = cause; eMe = epc; eMt = trapTval; eMpp = ePriv; eMpie = eMie; eMie = 0;
      ePriv = 3; eRpc = handler(mtvecIn, trapIsIrq, trapCode);
    end else if (resumeEn) begin
      if (resumePriv == 2) eErr = 1;
      else begin
        ePriv = resumePriv; eMie = resumeMie; eSie = resumeSie; eMprv = resumeMprv;
        eNmie = resumeNmie;
      end
    end
    if (anyT) eResv = 0; else if (reserveSet) eResv = 1;
    eTj = anyT && tjSecond;
    eRv = anyT;
  endtask

  task automatic compareAll();
    chk("R12 priv", curPriv, ePriv);
    chk("R12 priv not 2", 64'(curPriv == 2'd2), 64'd0);
    chk("R4 mie", mie, eMie);
    chk("R4 mpie", mpie, eMpie);
    chk("R4 mpp", mpp, eMpp);
    chk("R4 mcause", mcause, eMc);
    chk("R8 mepc", mepc, eMe);
    chk("R4 mtval", mtval, eMt);
    chk("R3 sie", sie, eSie);
    chk("R3 spie", spie, eSpie);
    chk("R3 spp", spp, eSpp);
    chk("R7 scause", scause, eSc);
    chk("R3 sepc", sepc, eSe);
    chk("R3 stval", stval, eSt);
    chk("R5 nmiCause", nmiCause, eNc);
    chk("R5 nmiEpc", nmiEpc, eNe);
    chk("R5 nmiPrevPriv", nmiPrevPriv, eNpp);
    chk("R6 nmiEnable", nmiEnable, eNmie);
    chk("R11 mprv", mprv, eMprv);
    chk("R9 resvValid", resvValid, eResv);
    chk("R8 tjCancel", tjCancel, eTj);
    chk("R10 redirectValid", redirectValid, eRv);
    chk("R10 redirectPc", redirectPc, eRpc);
    chk("R11 privError", privError, eErr);
  endtask

  // Drive current inputs for one cycle, then compare
  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    trapValid = 0; resumeEn = 0; reserveSet = 0; tjSecond = 0;
  endtask

  task automatic doResume(input logic [1:0] p, input logic m, input logic s, input logic n);
    idle(); resumeEn = 1; resumePriv = p; resumeMie = m; resumeSie = s; resumeNmie = n;
    resumeMprv = 0; step(); idle();
  endtask

  task automatic doTrap(input logic [CODE_W-1:0] c, input logic irq, input logic nmi);
    idle(); trapValid = 1; trapCode = c; trapIsIrq = irq; trapIsNmi = nmi;
    trapPc = $urandom; trapTval = $urandom; step(); idle();
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state visible while in reset
    compareAll();
    rstN = 1;
    // R1: first cycle after release still shows reset redirect
    chk("R1 redirectValid after release", redirectValid, 1'b1);
    chk("R1 redirectPc reset vector", redirectPc, RVEC);
    chk("R1 priv M", curPriv, 2'd3);
    chk("R1 nmiEnable", nmiEnable, 1'b1);
    idle(); step();

    // Directed: delegated exception raised from M stays in M (R2)
    medelegIn = 16'hFFFF; midelegIn = 16'h0000; mtvecIn = 32'h0000_4001; stvecIn = 32'h0000_8001;
    doResume(2'd3, 1, 1, 1);
    doTrap(4'd5, 0, 0);
    chk("R2 delegated from M handled in M", curPriv, 2'd3);
    chk("R10 vectored mode exception uses base", redirectPc, 32'h0000_4000);

    // Directed: from U with delegation goes to S, vectored irq at top code (R3, R10)
    midelegIn = 16'h8000;
    doResume(2'd0, 1, 1, 1);
    doTrap(4'd15, 1, 0);
    chk("R3 to S", curPriv, 2'd1);
    chk("R10 vectored irq offset", redirectPc, 32'h0000_8000 + 60);
    chk("R7 irq MSB", scause[XLEN-1], 1'b1);

    // Directed: supervisor absent forces M (R2)
    sModeImpl = 0;
    doResume(2'd1, 1, 1, 1);
    doTrap(4'd15, 1, 0);
    chk("R2 no S mode goes to M", curPriv, 2'd3);
    chk("R4 mpp from S", mpp, 2'd1);
    sModeImpl = 1;

    // Directed: back-to-back NMI, second masked (R5, R6)
    doResume(2'd0, 1, 0, 1);
    doTrap(4'd2, 1, 1);
    chk("R5 nmi target", redirectPc, NVEC);
    doTrap(4'd3, 1, 1);
    chk("R6 masked nmi no redirect", redirectValid, 1'b0);

    // Directed: table-jump second fetch (R8)
    idle(); trapValid = 1; trapCode = 4'd1; trapIsIrq = 0; trapIsNmi = 0;
    tjSecond = 1; tjPc = 32'hCAFE_0010; trapPc = 32'h1234_5678; step(); idle();
    chk("R8 tjCancel pulse", tjCancel, 1'b1);

    // Directed: reservation set then cleared by trap (R9)
    idle(); reserveSet = 1; step(); idle();
    chk("R9 reservation set", resvValid, 1'b1);
    doTrap(4'd7, 0, 0);
    chk("R9 reservation cleared", resvValid, 1'b0);

    // Directed: illegal restore privilege (R11)
    doResume(2'd2, 1, 1, 1);
    chk("R11 privError pulse", privError, 1'b1);
    chk("R11 priv unchanged", curPriv, 2'd3);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      trapValid  = ($urandom % 2) == 0;
      trapIsNmi  = ($urandom % 8) == 0;
      trapIsIrq  = $urandom % 2;
      trapCode   = $urandom;
      trapPc     = $urandom;
      trapTval   = $urandom;
      tjSecond   = ($urandom % 8) == 0;
      tjPc       = $urandom;
      if ($urandom % 16 == 0) begin
        midelegIn = $urandom; medelegIn = $urandom;
        mtvecIn = $urandom; stvecIn = $urandom;
        sModeImpl = ($urandom % 4) != 0;
      end
      resumeEn   = ($urandom % 3) == 0;
      resumePriv = $urandom;
      resumeMie  = $urandom; resumeSie = $urandom;
      resumeMprv = $urandom; resumeNmie = ($urandom % 4) != 0;
      reserveSet = $urandom;
      step();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule